// File: doc/BRIEF.md
# Quad-SPI Shared-Bus Word Memory Controller

This controller serves 32-bit word reads and writes on a 28-bit address by running quad-SPI transactions on one shared 4-bit data bus. Three devices sit on the bus, each with its own active-low select. The first is a read-only flash that has already been left in continuous-read mode, so a flash read needs no command byte. The other two are PSRAM chips that have already been put in four-wire command mode. Setting up these modes at power-up and refreshing the PSRAM are left to other logic.

A requester raises `req` with `we`, `addr` and `wdata` and holds them until `done` is seen high, then drops `req`. For a read, `rdata` holds the word while `done` is high. The serial clock runs at half the system clock. Each serial period has a low half, during which the controller changes the bus, and a high half, whose rising edge is where the device samples. Read data is captured on the system edge that ends the high half.

The sequencer has five states. `ST_IDLE` waits for a request. `ST_SEND` shifts out eight header nibbles. `ST_WAIT` runs the dummy or latency clocks of a read with the data lines released. `ST_XFER` moves eight data nibbles. `ST_GAP` keeps every select high before the next request is accepted. The transitions are as follows:
- `ST_IDLE` goes to `ST_SEND` on an accepted bus request.
- `ST_IDLE` goes to `ST_GAP` on a write aimed at the flash.
- `ST_SEND` goes to `ST_WAIT` after the last header nibble of a read.
- `ST_SEND` goes to `ST_XFER` after the last header nibble of a write.
- `ST_WAIT` goes to `ST_XFER` after the last dummy clock.
- `ST_XFER` goes to `ST_GAP` after the last data nibble.
- `ST_GAP` goes to `ST_IDLE` after two cycles.

Top module: `qspi_word_mem`

## Requirements
- R1: While reset is held and while idle, all three selects are high, SCK is low, the data lines are not driven, and `done` is low. The select and SCK pins are always output-enabled. In reset this gives `pad_out` = 0xC1 and `pad_oe` = 0xC9.
- R2: Device selection uses `addr[24]` and `addr[23]`. When `addr[24]` is 0 the flash is selected on pin 0. When `addr[24]` is 1 and `addr[23]` is 0, RAM A is selected on pin 6. When both are 1, RAM B is selected on pin 7. Bits 27:25 do not take part in the selection.
- R3: A flash read sends no command. It sends the low 24 address bits in 6 clocks, then the mode byte 0xA0 in 2 clocks, then 4 dummy clocks, then 8 data clocks, for 20 clocks in all.
- R4: A PSRAM read sends command 0x0B in 2 clocks and then 24 address bits in 6 clocks. Those 24 bits are a zero followed by the low 23 bits of `addr`. After that come 4 wait clocks and 8 data clocks, for 20 clocks in all.
- R5: A PSRAM write sends command 0x38 and the same 24-bit address, then 8 data clocks with no wait, for 16 clocks in all.
- R6: Within each byte the high nibble goes first. Bytes go in increasing address order, so `wdata[7:0]` and `rdata[7:0]` belong to the lowest address. Nibble bit 0 is on pin 1, bit 1 on pin 2, bit 2 on pin 4 and bit 3 on pin 5. SCK is on pin 3.
- R7: SCK toggles on every system clock while a select is low. A select stays low for exactly twice the number of serial clocks of the transaction.
- R8: The controller drives the data lines during every header clock and every write data clock. It releases them for every dummy, wait and read data clock.
- R9: Once a select rises, all selects stay high for at least two system clocks before the next transaction starts.
- R10: A write aimed at the flash region makes no bus activity. `done` is raised one cycle after the request is seen.
- R11: `done` is a single-cycle pulse. On a read, `rdata` carries the word read while `done` is high.
- R12: At most one select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Transfer request, held until done |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 28 | Byte address of the word |
| wdata | input | 32 | Word to write |
| rdata | output | 32 | Word read, valid with done |
| done | output | 1 | One-cycle completion pulse |
| pad_in | input | 8 | Pin inputs (data on bits 1, 2, 4, 5) |
| pad_out | output | 8 | Pin outputs: selects, SCK, data |
| pad_oe | output | 8 | Pin output enables |

## Verification
Flash reads are swept over addresses spread across the whole 16 MB region, including ones with bits 27:25 set. Each returned word is compared with a byte pattern computed from its address, which exposes nibble swaps, byte-order errors, a shifted capture edge and wrong address truncation. For both PSRAM chips, words made of walking ones and mixed patterns are written to the same offsets and read back. The bench checks the bytes stored in each modelled chip, so it can distinguish the two chips and catch faults in the command, the 23-bit truncation, the write ordering and the read path. Writes to flash, back-to-back requests and the serial clock count of each transaction cover the gap, the pulse width and the release of the data lines.

// File: rtl/qspi_mem_pkg.sv
package qspi_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_XFER,
        ST_GAP
    } seq_state_t;

    typedef enum logic [1:0] {
        DEV_FLASH = 2'd0,
        DEV_RAM_A = 2'd1,
        DEV_RAM_B = 2'd2
    } mem_dev_t;

    function automatic logic [31:0] swap_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/qspi_addr_decode.sv
module qspi_addr_decode
    import qspi_mem_pkg::*;
#(
    parameter int          ADDR_W     = 28,
    parameter int          FLASH_BITS = 24,
    parameter int          RAM_BITS   = 23,
    parameter logic [7:0]  MODE_BYTE  = 8'hA0,
    parameter logic [7:0]  CMD_READ   = 8'h0B,
    parameter logic [7:0]  CMD_WRITE  = 8'h38
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  we,
    output mem_dev_t              dev,
    output logic [FLASH_BITS+7:0] header
);
    localparam int PAD_BITS = FLASH_BITS - RAM_BITS;

    always_comb begin
        if (!addr[FLASH_BITS]) begin
            dev    = DEV_FLASH;
            header = {addr[FLASH_BITS-1:0], MODE_BYTE};
        end else begin
            dev    = addr[RAM_BITS] ? DEV_RAM_B : DEV_RAM_A;
            header = {(we ? CMD_WRITE : CMD_READ), {PAD_BITS{1'b0}},
                      addr[RAM_BITS-1:0]};
        end
    end

endmodule

// File: rtl/qspi_pin_map.sv
module qspi_pin_map #(
    parameter int N_CS = 3
) (
    input  logic [N_CS-1:0] cs_n,
    input  logic            sck,
    input  logic [3:0]      sd_o,
    input  logic [3:0]      sd_oe,
    input  logic [7:0]      pad_in,
    output logic [7:0]      pad_out,
    output logic [7:0]      pad_oe,
    output logic [3:0]      sd_i
);
    localparam int CS_POS [3] = '{0, 6, 7};
    localparam int SD_POS [4] = '{1, 2, 4, 5};
    localparam int SCK_POS    = 3;

    always_comb begin
        pad_out = '0;
        pad_oe  = '0;
        sd_i    = '0;
        pad_out[SCK_POS] = sck;
        pad_oe[SCK_POS]  = 1'b1;
        for (int c = 0; c < N_CS; c++) begin
            pad_out[CS_POS[c]] = cs_n[c];
            pad_oe[CS_POS[c]]  = 1'b1;
        end
        for (int b = 0; b < 4; b++) begin
            pad_out[SD_POS[b]] = sd_o[b];
            pad_oe[SD_POS[b]]  = sd_oe[b];
            sd_i[b]            = pad_in[SD_POS[b]];
        end
    end

endmodule

// File: rtl/qspi_word_mem.sv
module qspi_word_mem
    import qspi_mem_pkg::*;
#(
    parameter int ADDR_W     = 28,
    parameter int DATA_W     = 32,
    parameter int FLASH_BITS = 24,
    parameter int RAM_BITS   = 23,
    parameter int FL_DUMMY   = 4,
    parameter int RAM_WAIT   = 4,
    parameter int GAP_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    input  logic [7:0]        pad_in,
    output logic [7:0]        pad_out,
    output logic [7:0]        pad_oe
);
    localparam int HDR_W     = FLASH_BITS + 8;
    localparam int HDR_NIBS  = HDR_W / 4;
    localparam int DATA_NIBS = DATA_W / 4;
    localparam int CNT_W     = $clog2(HDR_NIBS + DATA_NIBS + FL_DUMMY + RAM_WAIT);
    localparam int GAP_W     = $clog2(GAP_CYC + 1);

    seq_state_t         st, st_n;
    mem_dev_t           dec_dev, dev_q;
    logic [HDR_W-1:0]   dec_hdr, hdr_q;
    logic [DATA_W-1:0]  dsh_q;
    logic [CNT_W-1:0]   cnt_q, limit;
    logic [GAP_W-1:0]   gap_q;
    logic               phase_q, we_q, last, active;
    logic [2:0]         cs_n;
    logic               sck;
    logic [3:0]         sd_o, sd_oe, sd_i;
    logic               flash_wr;

    qspi_addr_decode #(
        .ADDR_W    (ADDR_W),
        .FLASH_BITS(FLASH_BITS),
        .RAM_BITS  (RAM_BITS)
    ) u_dec (
        .addr  (addr),
        .we    (we),
        .dev   (dec_dev),
        .header(dec_hdr)
    );

    qspi_pin_map #(.N_CS(3)) u_pins (
        .cs_n   (cs_n),
        .sck    (sck),
        .sd_o   (sd_o),
        .sd_oe  (sd_oe),
        .pad_in (pad_in),
        .pad_out(pad_out),
        .pad_oe (pad_oe),
        .sd_i   (sd_i)
    );

    assign flash_wr = we && (dec_dev == DEV_FLASH);

    // nibble count of the current phase
    always_comb begin
        unique case (st)
            ST_SEND: limit = CNT_W'(HDR_NIBS);
            ST_WAIT: limit = (dev_q == DEV_FLASH) ? CNT_W'(FL_DUMMY) : CNT_W'(RAM_WAIT);
            ST_XFER: limit = CNT_W'(DATA_NIBS);
            default: limit = CNT_W'(1);
        endcase
    end

    assign last = phase_q && (cnt_q == limit - CNT_W'(1));

    // next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE: if (req)  st_n = flash_wr ? ST_GAP : ST_SEND;
            ST_SEND: if (last) st_n = we_q ? ST_XFER : ST_WAIT;
            ST_WAIT: if (last) st_n = ST_XFER;
            ST_XFER: if (last) st_n = ST_GAP;
            ST_GAP:  if (gap_q == GAP_W'(GAP_CYC - 1)) st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            phase_q <= 1'b0;
            cnt_q   <= '0;
            gap_q   <= '0;
            dev_q   <= DEV_FLASH;
            we_q    <= 1'b0;
            hdr_q   <= '0;
            dsh_q   <= '0;
            rdata   <= '0;
            done    <= 1'b0;
        end else begin
            st   <= st_n;
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    phase_q <= 1'b0;
                    cnt_q   <= '0;
                    gap_q   <= '0;
                    if (req) begin
                        dev_q <= dec_dev;
                        we_q  <= we;
                        hdr_q <= dec_hdr;
                        dsh_q <= swap_bytes(wdata);
                        if (flash_wr) done <= 1'b1;
                    end
                end
                ST_SEND, ST_WAIT, ST_XFER: begin
                    phase_q <= ~phase_q;
                    if (phase_q) begin
                        cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
                        if (st == ST_SEND) hdr_q <= {hdr_q[HDR_W-5:0], 4'h0};
                        if (st == ST_XFER) begin
                            dsh_q <= {dsh_q[DATA_W-5:0], (we_q ? 4'h0 : sd_i)};
                            if (last) begin
                                done <= 1'b1;
                                if (!we_q) rdata <= swap_bytes({dsh_q[DATA_W-5:0], sd_i});
                            end
                        end
                    end
                end
                ST_GAP: gap_q <= gap_q + GAP_W'(1);
                default: ;
            endcase
        end
    end

    // pin-level outputs
    always_comb begin
        active = (st == ST_SEND) || (st == ST_WAIT) || (st == ST_XFER);
        cs_n   = 3'b111;
        if (active) cs_n[dev_q] = 1'b0;
        sck    = active && phase_q;
        sd_o   = 4'h0;
        sd_oe  = 4'h0;
        unique case (st)
            ST_SEND: begin
                sd_o  = hdr_q[HDR_W-1:HDR_W-4];
                sd_oe = 4'hF;
            end
            ST_XFER: if (we_q) begin
                sd_o  = dsh_q[DATA_W-1:DATA_W-4];
                sd_oe = 4'hF;
            end
            default: ;
        endcase
    end

    // assertions
    logic [2:0] pin_cs_n;
    logic       cs_low;
    assign pin_cs_n = {pad_out[7], pad_out[6], pad_out[0]};
    assign cs_low   = (pin_cs_n != 3'b111);

    a_r12_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~pin_cs_n));

    a_r7_sck_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_low && $past(cs_low)) |-> (pad_out[3] != $past(pad_out[3])));

    a_r1_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |-> !pad_out[3]);

    a_r9_gap_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&pin_cs_n) |=> (&pin_cs_n));

    a_r8_release_after_header: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st == ST_SEND) && st == ST_WAIT) |-> (pad_oe[1] == 1'b0 && pad_oe[5] == 1'b0));

    a_r10_flash_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && req && we && !addr[FLASH_BITS]) |=> (done && (&pin_cs_n)));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/qspi_word_mem_test.sv
module qspi_word_mem_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [27:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        done;
    logic [7:0]  pad_in;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    qspi_word_mem uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .done(done),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [7:0] fbyte(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] fword(input logic [23:0] a);
        return {fbyte(a + 24'd3), fbyte(a + 24'd2), fbyte(a + 24'd1), fbyte(a)};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- device model on the shared bus ----------------
    logic [2:0]  csn;
    logic [3:0]  m_do, m_oe, m_di;
    assign csn  = {pad_out[7], pad_out[6], pad_out[0]};
    assign m_do = {pad_out[5], pad_out[4], pad_out[2], pad_out[1]};
    assign m_oe = {pad_oe[5], pad_oe[4], pad_oe[2], pad_oe[1]};
    assign pad_in = {2'b00, m_di[3], m_di[2], 1'b0, m_di[1], m_di[0], 1'b0};

    logic [7:0]  ram_a [256];
    logic [7:0]  ram_b [256];
    logic        m_prev_sck = 1'b0, m_prev_act = 1'b0;
    logic [2:0]  m_dev = 3'b111;
    logic [31:0] m_hdr = '0, m_wd = '0, m_last_hdr = '0;
    int          m_cnt = 0, m_last_clk = 0, m_low = 0, m_last_low = 0;
    int          m_hi = 1000, m_min_gap = 1000, m_txn = 0, m_oe_bad = 0, m_multi = 0;
    logic [2:0]  m_last_dev = 3'b111;

    always @(posedge clk) begin : model
        logic        act, wr;
        logic [23:0] ba;
        logic [7:0]  bv;
        int          bi;
        if (!rst_n) begin
            m_prev_sck = 1'b0;
            m_prev_act = 1'b0;
            m_di      <= 4'h0;
        end else begin
            act = (csn != 3'b111);
            if ($countones(~csn) > 1) m_multi++;
            if (act && !m_prev_act) begin
                if (m_hi < m_min_gap) m_min_gap = m_hi;
                m_cnt = 0; m_hdr = '0; m_wd = '0; m_low = 0; m_txn++; m_dev = csn;
            end
            if (!act && m_prev_act) begin
                m_last_clk = m_cnt; m_last_hdr = m_hdr; m_last_low = m_low;
                m_last_dev = m_dev; m_hi = 0;
            end
            if (act) m_low++; else m_hi++;
            wr = (m_dev != 3'b110) && (m_hdr[31:24] == 8'h38) && (m_cnt >= 8);
            if (act && pad_out[3] && !m_prev_sck) begin
                if (m_cnt < 8) begin
                    m_hdr = {m_hdr[27:0], m_do};
                    if (m_oe != 4'hF) m_oe_bad++;
                end else if (wr) begin
                    if (m_oe != 4'hF) m_oe_bad++;
                    m_wd = {m_wd[27:0], m_do};
                    if (m_cnt == 15) begin
                        for (int k = 0; k < 4; k++) begin
                            ba = m_hdr[23:0] + 24'(k);
                            bv = m_wd[31 - 8*k -: 8];
                            if (m_dev == 3'b101) ram_a[ba[7:0]] = bv;
                            else                 ram_b[ba[7:0]] = bv;
                        end
                    end
                end else if (m_oe != 4'h0) m_oe_bad++;
                m_cnt++;
            end
            if (act && !pad_out[3] && m_prev_sck && !wr && m_cnt >= 12 && m_cnt < 20) begin
                bi = (m_cnt - 12) / 2;
                if (m_dev == 3'b110) begin
                    ba = m_hdr[31:8] + 24'(bi);
                    bv = fbyte(ba);
                end else begin
                    ba = m_hdr[23:0] + 24'(bi);
                    bv = (m_dev == 3'b101) ? ram_a[ba[7:0]] : ram_b[ba[7:0]];
                end
                m_di <= (m_cnt % 2 == 0) ? bv[7:4] : bv[3:0];
            end
            m_prev_sck = pad_out[3];
            m_prev_act = act;
        end
    end

    // ---------------- request task ----------------
    task automatic xfer(input logic w, input logic [27:0] a, input logic [31:0] d,
                        output logic [31:0] q, output int lat);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!done && lat < 200);
        q = rdata;
        req = 1'b0; we = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R11 done single pulse", {63'd0, done}, 64'd0);
    endtask

    task automatic check_bus(input string tag, input logic [2:0] exp_dev,
                             input logic [31:0] exp_hdr, input int exp_clk);
        chk(m_last_dev == exp_dev, {tag, " R2 select"}, 64'(m_last_dev), 64'(exp_dev));
        chk(m_last_hdr == exp_hdr, {tag, " header"}, 64'(m_last_hdr), 64'(exp_hdr));
        chk(m_last_clk == exp_clk, {tag, " clock count"}, 64'(m_last_clk), 64'(exp_clk));
        chk(m_last_low == 2 * exp_clk, "R7 select low time", 64'(m_last_low), 64'(2 * exp_clk));
    endtask

    // watchdog
    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] q, w;
        logic [27:0] a;
        int          lat, t0;

        for (int i = 0; i < 256; i++) begin
            ram_a[i] = 8'h00;
            ram_b[i] = 8'h00;
        end

        repeat (3) @(negedge clk);
        chk(pad_out == 8'hC1, "R1 reset pad_out", 64'(pad_out), 64'hC1);
        chk(pad_oe == 8'hC9, "R1 reset pad_oe", 64'(pad_oe), 64'hC9);
        chk(done == 1'b0, "R1 reset done", 64'(done), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(pad_out == 8'hC1 && pad_oe == 8'hC9, "R1 idle pins",
            64'({pad_out, pad_oe}), 64'hC1C9);

        // R3 R6: flash read sweep
        for (int i = 0; i < 20; i++) begin
            a = 28'((i * 32'h00C3_5A4) & 32'h00FF_FFFC);
            if (i % 4 == 3) a = a | 28'hE00_0000;   // bits 27:25 ignored (R2)
            xfer(1'b0, a, 32'h0, q, lat);
            chk(q == fword(a[23:0]), "R3 R6 flash word", 64'(q), 64'(fword(a[23:0])));
            check_bus("R3 flash", 3'b110, {a[23:0], 8'hA0}, 20);
        end

        // R4 R5 R6: PSRAM write/read on both chips, same offsets
        for (int i = 0; i < 8; i++) begin
            w = (32'h1 << (i * 4)) ^ (32'h9E37_79B9 * 32'(i + 1));
            a = 28'h100_0000 | 28'(i * 8) | ((i % 2 == 1) ? 28'h07F_FF00 : 28'h0);
            xfer(1'b1, a, w, q, lat);
            check_bus("R5 ramA write", 3'b101, {8'h38, 1'b0, a[22:0]}, 16);
            chk({ram_a[a[7:0] + 8'd3], ram_a[a[7:0] + 8'd2], ram_a[a[7:0] + 8'd1], ram_a[a[7:0]]} == w,
                "R6 ramA bytes little-endian",
                64'({ram_a[a[7:0] + 8'd3], ram_a[a[7:0] + 8'd2], ram_a[a[7:0] + 8'd1], ram_a[a[7:0]]}), 64'(w));
            xfer(1'b1, a | 28'h080_0000, ~w, q, lat);
            check_bus("R5 ramB write", 3'b011, {8'h38, 1'b0, a[22:0]}, 16);
            xfer(1'b0, a, 32'h0, q, lat);
            chk(q == w, "R4 ramA read", 64'(q), 64'(w));
            check_bus("R4 ramA read", 3'b101, {8'h0B, 1'b0, a[22:0]}, 20);
            xfer(1'b0, a | 28'h080_0000, 32'h0, q, lat);
            chk(q == ~w, "R4 ramB read", 64'(q), 64'(~w));
            check_bus("R4 ramB read", 3'b011, {8'h0B, 1'b0, a[22:0]}, 20);
        end

        // R10: writes aimed at flash make no bus activity
        for (int i = 0; i < 4; i++) begin
            t0 = m_txn;
            a = 28'(32'h0012_3400 + 32'(i * 4));
            xfer(1'b1, a, 32'hFFFF_FFFF, q, lat);
            chk(lat == 1, "R10 flash write done latency", 64'(lat), 64'd1);
            chk(m_txn == t0, "R10 flash write no bus activity", 64'(m_txn), 64'(t0));
            xfer(1'b0, a, 32'h0, q, lat);
            chk(q == fword(a[23:0]), "R10 flash unchanged", 64'(q), 64'(fword(a[23:0])));
        end

        repeat (4) @(negedge clk);
        chk(m_oe_bad == 0, "R8 data line drive/release", 64'(m_oe_bad), 64'd0);
        chk(m_min_gap >= 2, "R9 select high gap", 64'(m_min_gap), 64'd2);
        chk(m_multi == 0, "R12 one select low", 64'(m_multi), 64'd0);
        chk(pad_out == 8'hC1 && pad_oe == 8'hC9, "R1 idle after traffic",
            64'({pad_out, pad_oe}), 64'hC1C9);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule